// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Collision Guard

This block moves one byte at a time over a four-wire synchronous serial bus. A control bit makes it either the bus master or a slave. As master it makes the serial clock from the system clock through a programmable even divisor. It emits exactly eight clock pulses per byte and shifts the most significant bit first. As slave it takes the clock from the bus, passes clock, select and data through two-flop synchronizers, and takes part only while its select input is low. A configuration bit picks which clock edge samples data; the opposite edge launches it.

The select input does two jobs. In slave mode it gates the transfer. In master mode it is a bus-collision input. When it is pulled low, the clock and MOSI output enables drop in the same cycle through combinational gating. A sticky fault flag is then raised, and it blocks new master transfers until software clears it.

Software reaches the block through four byte-wide registers. Address 0 holds the configuration, address 1 the status, address 2 the data and address 3 the divisor. Each bus pin is brought out as an input, an output and an output enable.

Top module: `spi_mf_top`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0, address 3 reads 3, and sclkOe, mosiOe and misoOe are low.
- R2: With address 0 bit0 (enable) = 1 and bit1 (master) = 1, writing address 2 while idle starts a transfer. sclkOut then gives exactly eight high pulses, is low at all other times, and mosiOut presents the written byte most significant bit first.
- R3: Address 0 bit2 = 0 samples on the rising clock edge and launches on the falling edge, with the first bit already valid before the first rising edge. Bit2 = 1 launches on the rising edge and samples on the falling edge.
- R4: Status bit0 (busy) is high from the cycle after the data write until the sixteenth clock transition. At that transition bit1 (done) is set, and address 2 returns the byte received on misoIn, MSB first.
- R5: With address 3 holding value h, every serial clock half period lasts h+1 system cycles.
- R6: In master mode, ssIn low forces sclkOe and mosiOe low in the same cycle, aborts any transfer (sclkOut low, busy low), and sets status bit2 (fault) within four cycles.
- R7: The fault flag stays set until bit2 is written as 1 to address 1. While it is set, a data write starts no transfer and sclkOe stays low.
- R8: In slave mode (bit1 = 0, bit0 = 1) with ssIn low, the block samples eight bits from mosiIn on the sample edges of sclkIn. It then sets done and returns the byte at address 2, and it sends the byte last written to address 2 on misoOut, MSB first.
- R9: A slave with ssIn high ignores sclkIn edges (no done, busy stays low) and holds misoOe low.
- R10: If ssIn rises in the middle of a byte, the slave discards the partial byte and done stays low. The next full byte is received correctly.
- R11: Clearing the enable bit drives misoOe low.
- R12: Writing address 1 with bit1 = 1 clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | asynchronous active-low reset |
| regAddr | input | 2 | register address |
| regWe | input | 1 | register write strobe |
| regWdata | input | 8 | register write data |
| regRdata | output | 8 | register read data (combinational) |
| sclkIn | input | 1 | serial clock from bus (slave) |
| sclkOut | output | 1 | serial clock to bus (master) |
| sclkOe | output | 1 | serial clock driver enable |
| mosiIn | input | 1 | master-out data from bus (slave) |
| mosiOut | output | 1 | master-out data to bus |
| mosiOe | output | 1 | master-out driver enable |
| misoIn | input | 1 | slave-out data from bus (master) |
| misoOut | output | 1 | slave-out data to bus |
| misoOe | output | 1 | slave-out driver enable |
| ssIn | input | 1 | select / collision input, active low |

## Verification
Register writes take effect at the next rising edge. The master clock changes h+1 edges apart, and busy, done and the received byte all update at the same edge as the final clock transition. The bench therefore samples every output on the falling system clock edge and compares the spacing between transitions in whole cycles. Driver enables react to ssIn combinationally, so they are checked one nanosecond after ssIn changes. The fault flag and the slave's results travel through the two-flop synchronizers plus one register, so they are read several cycles after the triggering bus event, never at the edge itself. Slave bits are driven eight cycles per half period, which leaves room for the synchronizer delay before each capture of misoOut.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic load;    // copy write data into transmit shifter
    logic shift;   // advance transmit shifter by one bit
    logic sample;  // shift sBit into receive shifter
    logic sBit;    // bit being sampled
    logic commit;  // byte complete: publish received byte
  } dpStrobe_t;
endpackage

// File: rtl/spi_mf_ctl.sv
module spi_mf_ctl
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W = 8,
  parameter int DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWe,
  input  logic [7:0]       regWdata,
  input  logic             sclkIn,
  input  logic             mosiIn,
  input  logic             misoIn,
  input  logic             ssIn,
  output dpStrobe_t        stb,
  output logic             cfgEn,
  output logic             cfgMaster,
  output logic             cfgSampFall,
  output logic [DIV_W-1:0] divHalf,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             sclkOut,
  output logic             sclkOe,
  output logic             mosiOe,
  output logic             misoOe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic ssS1, ssS2, sckS1, sckS2, sckS3, mosiS1, mosiS2;
  logic mBusy;
  logic [DIV_W-1:0] divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssS1 <= 1'b1; ssS2 <= 1'b1;
      sckS1 <= 1'b0; sckS2 <= 1'b0; sckS3 <= 1'b0;
      mosiS1 <= 1'b0; mosiS2 <= 1'b0;
    end else begin
      ssS1 <= ssIn; ssS2 <= ssS1;
      sckS1 <= sclkIn; sckS2 <= sckS1; sckS3 <= sckS2;
      mosiS1 <= mosiIn; mosiS2 <= mosiS1;
    end
  end

  logic writeCtrl, writeStat, writeData, writeDiv;
  assign writeCtrl = regWe && regAddr == ADDR_CTRL;
  assign writeStat = regWe && regAddr == ADDR_STAT;
  assign writeData = regWe && regAddr == ADDR_DATA;
  assign writeDiv  = regWe && regAddr == ADDR_DIV;

  logic slvAct, faultHit, mAbort, mTick, startM;
  assign slvAct   = cfgEn && !cfgMaster && !ssS2;
  assign faultHit = cfgEn && cfgMaster && !ssS2;
  assign mAbort   = mBusy && (!cfgEn || !cfgMaster || !ssS2);
  assign mTick    = mBusy && !mAbort && divCnt == divHalf;
  assign startM   = writeData && cfgEn && cfgMaster && !mBusy && !fault && !faultHit && ssIn;

  logic sRise, sFall, edgeEv, edgeRise, sampEv, launchEv, mDone, slvDone;
  assign sRise = sckS2 && !sckS3;
  assign sFall = !sckS2 && sckS3;
  assign edgeEv   = cfgMaster ? mTick : (slvAct && (sRise || sFall));
  assign edgeRise = cfgMaster ? !sclkOut : sRise;
  assign sampEv   = edgeEv && (edgeRise != cfgSampFall);
  assign launchEv = edgeEv && (edgeRise == cfgSampFall);
  assign mDone    = cfgMaster && mTick && edgeCnt == LAST_EDGE;
  assign slvDone  = !cfgMaster && sampEv && bitCnt == LAST_BIT;

  assign busy = mBusy || bitCnt != '0;

  always_comb begin
    stb.load   = writeData && !busy;
    stb.shift  = launchEv && bitCnt != '0 && bitCnt != FULL_CNT;
    stb.sample = sampEv;
    stb.sBit   = cfgMaster ? misoIn : mosiS2;
    stb.commit = mDone || slvDone;
  end

  // master clock generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 1'b0; divCnt <= '0; edgeCnt <= '0; sclkOut <= 1'b0;
    end else if (startM) begin
      mBusy <= 1'b1; divCnt <= '0; edgeCnt <= '0; sclkOut <= 1'b0;
    end else if (mAbort) begin
      mBusy <= 1'b0; sclkOut <= 1'b0;
    end else if (mTick) begin
      divCnt <= '0;
      sclkOut <= !sclkOut;
      edgeCnt <= edgeCnt + 1'b1;
      if (edgeCnt == LAST_EDGE) mBusy <= 1'b0;
    end else if (mBusy) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // bit counter shared by both roles
  logic cntClear;
  assign cntClear = mDone || mAbort || slvDone || (cfgMaster && !mBusy) || (!cfgMaster && !slvAct);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (cntClear) bitCnt <= '0;
    else if (sampEv) bitCnt <= bitCnt + 1'b1;
  end

  // software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn <= 1'b0; cfgMaster <= 1'b0; cfgSampFall <= 1'b0;
      divHalf <= DIV_W'(DIV_RST); done <= 1'b0; fault <= 1'b0;
    end else begin
      if (writeCtrl) begin
        cfgEn <= regWdata[0]; cfgMaster <= regWdata[1]; cfgSampFall <= regWdata[2];
      end
      if (writeDiv) divHalf <= regWdata[DIV_W-1:0];
      if (stb.commit) done <= 1'b1;
      else if (writeStat && regWdata[1]) done <= 1'b0;
      if (faultHit) fault <= 1'b1;
      else if (writeStat && regWdata[2]) fault <= 1'b0;
    end
  end

  assign sclkOe = cfgEn && cfgMaster && ssIn && !fault;
  assign mosiOe = sclkOe;
  assign misoOe = slvAct;

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !mBusy |-> !sclkOut);
  p_edge_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EDGE_W'(2 * DATA_W));
  p_bit_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT);
  p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!sclkOe && !mosiOe));
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !(writeStat && regWdata[2])) |=> fault);
  p_ss_discard_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMaster && ssS2) |=> bitCnt == '0);
  p_miso_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |-> !misoOe);
endmodule

// File: rtl/spi_mf_dp.sv
module spi_mf_dp
  import spi_mf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] wData,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txSh, rxSh, rxNext;
  assign rxNext = {rxSh[DATA_W-2:0], stb.sBit};
  assign txBit = txSh[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0; rxSh <= '0; rxData <= '0;
    end else begin
      if (stb.load) txSh <= wData;
      else if (stb.shift) txSh <= {txSh[DATA_W-2:0], 1'b0};
      if (stb.sample) rxSh <= rxNext;
      if (stb.commit) rxData <= stb.sample ? rxNext : rxSh;
    end
  end

  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load && (stb.shift || stb.commit)));
endmodule

// File: rtl/spi_mf_top.sv
module spi_mf_top
  import spi_mf_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DIV_RST = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       sclkIn,
  output logic       sclkOut,
  output logic       sclkOe,
  input  logic       mosiIn,
  output logic       mosiOut,
  output logic       mosiOe,
  input  logic       misoIn,
  output logic       misoOut,
  output logic       misoOe,
  input  logic       ssIn
);
  localparam int DATA_W = 8;

  dpStrobe_t stb;
  logic cfgEn, cfgMaster, cfgSampFall, busy, done, fault, txBit;
  logic [DIV_W-1:0] divHalf;
  logic [DATA_W-1:0] rxData;

  spi_mf_ctl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .sclkIn(sclkIn), .mosiIn(mosiIn), .misoIn(misoIn), .ssIn(ssIn), .stb(stb),
    .cfgEn(cfgEn), .cfgMaster(cfgMaster), .cfgSampFall(cfgSampFall), .divHalf(divHalf),
    .busy(busy), .done(done), .fault(fault), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .mosiOe(mosiOe), .misoOe(misoOe)
  );

  spi_mf_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(regWdata), .txBit(txBit), .rxData(rxData)
  );

  assign mosiOut = txBit;
  assign misoOut = txBit;

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = {5'b0, cfgSampFall, cfgMaster, cfgEn};
      ADDR_STAT: regRdata = {5'b0, fault, done, busy};
      ADDR_DATA: regRdata = rxData;
      default:   regRdata = 8'(divHalf);
    endcase
  end
endmodule

// File: tb/test_spi_mf_top.sv
`timescale 1ns/1ps
module test_spi_mf_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic sclkIn = 1'b0, mosiIn = 1'b0, misoIn = 1'b0, ssIn = 1'b1;
  logic sclkOut, sclkOe, mosiOut, mosiOe, misoOut, misoOe;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_mf_top i_spi_mf_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn),
    .misoOut(misoOut), .misoOe(misoOe), .ssIn(ssIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(0, d); chk("R1 ctrl", d, 0);
    regRead(1, d); chk("R1 status", d, 0);
    regRead(2, d); chk("R1 data", d, 0);
    regRead(3, d); chk("R1 divisor", d, 3);
    chk("R1 enables", {sclkOe, mosiOe, misoOe}, 0);
  endtask

  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] slv, input logic sf,
                            input logic [7:0] h);
    int pulses = 0, idx = 0, edges = 0, last = 0, badInt = 0;
    logic [7:0] got = 0, d;
    logic prev;
    ssIn = 1'b1;
    regWrite(3, h);
    regWrite(0, {5'b0, sf, 2'b11});
    misoIn = slv[7];
    regWrite(2, tx);
    regRead(1, d); chk("R4 busy after write", d[0], 1);
    prev = sclkOut; last = cyc;
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      if (sclkOut !== prev) begin
        edges++;
        if (edges > 1 && (cyc - last) != int'(h) + 1) badInt++;
        last = cyc;
        if (sclkOut) pulses++;
        if (sclkOut != sf) begin
          got = {got[6:0], mosiOut};
          idx++;
          if (idx < 8) misoIn = slv[7 - idx];
        end
        prev = sclkOut;
      end
      if (!regRdata[0]) break;
    end
    chk("R2 pulse count", pulses, 8);
    chk("R2 clock transitions", edges, 16);
    chk(sf ? "R3 falling-sample mosi" : "R3 rising-sample mosi", got, tx);
    chk("R5 half period", badInt, 0);
    chk("R2 idle clock low", sclkOut, 0);
    regRead(1, d); chk("R4 done set busy clear", d[1:0], 2'b10);
    regRead(2, d); chk("R4 received byte", d, slv);
    regWrite(1, 8'h02);
    regRead(1, d); chk("R12 done cleared", d[1], 0);
  endtask

  task automatic testFault();
    logic [7:0] d;
    ssIn = 1'b1;
    regWrite(3, 8'd3);
    regWrite(0, 8'h03);
    regWrite(2, 8'hA5);
    repeat (20) @(negedge clk);
    chk("R6 drivers on before fault", {sclkOe, mosiOe}, 2'b11);
    ssIn = 1'b0; #1;
    chk("R6 drivers off at once", {sclkOe, mosiOe}, 2'b00);
    repeat (4) @(negedge clk);
    regRead(1, d); chk("R6 fault set, aborted", d, 8'h04);
    chk("R6 clock low after abort", sclkOut, 0);
    ssIn = 1'b1;
    regWrite(2, 8'h3C);
    repeat (10) @(negedge clk);
    regRead(1, d); chk("R7 sticky, no start", d, 8'h04);
    chk("R7 clock driver held off", sclkOe, 0);
    regWrite(1, 8'h04);
    regRead(1, d); chk("R7 fault cleared", d[2], 0);
    chk("R7 drivers back", sclkOe, 1);
  endtask

  task automatic slaveByte(input logic [7:0] din, input logic [7:0] load, input logic sf,
                           input int nbits);
    logic [7:0] got = 0, d;
    regWrite(0, {5'b0, sf, 2'b01});
    regWrite(2, load);
    sclkIn = 1'b0; ssIn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 miso enabled", misoOe, 1);
    for (int i = 0; i < nbits; i++) begin
      if (!sf) begin
        mosiIn = din[7 - i];
        repeat (8) @(negedge clk);
        got = {got[6:0], misoOut};
        sclkIn = 1'b1;
        repeat (8) @(negedge clk);
        sclkIn = 1'b0;
      end else begin
        sclkIn = 1'b1;
        mosiIn = din[7 - i];
        repeat (8) @(negedge clk);
        got = {got[6:0], misoOut};
        sclkIn = 1'b0;
        repeat (8) @(negedge clk);
      end
    end
    if (nbits < 8) begin
      ssIn = 1'b1;
      repeat (6) @(negedge clk);
      regRead(1, d); chk("R10 partial byte dropped", d[1:0], 2'b00);
    end else begin
      repeat (6) @(negedge clk);
      regRead(1, d); chk("R8 slave done", d[1:0], 2'b10);
      regRead(2, d); chk("R8 slave received", d, din);
      chk("R8 slave sent", got, load);
      ssIn = 1'b1;
      regWrite(1, 8'h02);
    end
  endtask

  task automatic testIgnore();
    logic [7:0] d;
    regWrite(0, 8'h01);
    ssIn = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mosiIn = i[0];
      repeat (8) @(negedge clk); sclkIn = 1'b1;
      repeat (8) @(negedge clk); sclkIn = 1'b0;
      if (misoOe) chk("R9 miso off while deselected", misoOe, 0);
    end
    repeat (6) @(negedge clk);
    regRead(1, d); chk("R9 edges ignored", d[1:0], 2'b00);
    chk("R9 miso off", misoOe, 0);
  endtask

  task automatic testDisable();
    regWrite(0, 8'h01);
    ssIn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 miso on when enabled", misoOe, 1);
    regWrite(0, 8'h00);
    #1; chk("R11 miso off when disabled", misoOe, 0);
    ssIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    masterXfer(8'hA5, 8'h3C, 1'b0, 8'd3);
    masterXfer(8'h5A, 8'hC3, 1'b1, 8'd3);
    masterXfer(8'h81, 8'h7E, 1'b0, 8'd0);
    masterXfer(8'h0F, 8'hF0, 1'b1, 8'd6);
    testFault();
    masterXfer(8'h96, 8'h69, 1'b0, 8'd2);
    slaveByte(8'hB4, 8'h2D, 1'b0, 8);
    slaveByte(8'h4B, 8'hD2, 1'b1, 8);
    testIgnore();
    slaveByte(8'hFF, 8'h00, 1'b0, 3);
    slaveByte(8'h6C, 8'h93, 1'b0, 8);
    testDisable();
    finishRun();
  end
endmodule